// File: doc/BRIEF.md
# Per-Layer DMA Stall and Read-Latency Counters

This block holds debug performance counters for one processing sub-unit that runs its work in two independently launched register groups. For each group it keeps three counters: cycles in which the read DMA was stalled, cycles in which the write DMA was stalled, and the running sum of outstanding read requests. That sum is the read latency accumulated over the layer. A counter is cleared only when its own group starts a new layer or DMA group. Until the next start it holds its value, so software can read it as often as it likes after the layer has finished.

A single enable bit gates the whole set to save power. While the bit is low, no counter advances. A group start still clears that group's counters while the bit is low. Counters saturate at all-ones and never wrap. A small combinational read port selects one counter by group index and counter kind.

Top module: `perf_layer_counters`

## Requirements
- R1: One cycle after `grp_start_i[g]` is high on a clock edge, all three counters of group g read zero. When a start and an increment condition occur together, the start takes priority.
- R2: While enabled and not starting, a group's read-stall counter and write-stall counter each rise by exactly 1 on every cycle in which that group's `rd_stall_i` or `wr_stall_i` bit is high. They are unchanged on cycles when the bit is low.
- R3: While enabled and not starting, a group's latency counter adds that group's `rd_ostd_i` field on every cycle. The field for group g is bits [g*OSTD_W +: OSTD_W].
- R4: While `cnt_en_i` is low, no counter changes, except that a group start still clears its group.
- R5: Every counter saturates at the all-ones value of CNT_W bits. An addition that would pass all-ones leaves the counter at all-ones, and a counter at all-ones stays there.
- R6: Read selection uses `rd_kind_i`: 0 selects read-stall, 1 selects write-stall, 2 selects latency, and 3 returns zero. `rd_grp_i` selects the group. `rd_data_o` follows the selection in the same cycle, and reading never alters a counter.
- R7: After asynchronous reset all counters read zero.
- R8: The two groups are independent. A start or condition on one group never changes the other group's counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counter enable for the whole sub-unit |
| grp_start_i | input | NUM_GRP | Per-group layer start pulse |
| rd_stall_i | input | NUM_GRP | Per-group read-DMA stall this cycle |
| wr_stall_i | input | NUM_GRP | Per-group write-DMA stall this cycle |
| rd_ostd_i | input | NUM_GRP*OSTD_W | Per-group count of outstanding read requests |
| rd_grp_i | input | GRP_W | Read port group select |
| rd_kind_i | input | 2 | Read port counter kind select |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
The bench builds the block with CNT_W=8 and OSTD_W=4 and keeps the default of two groups. With an 8-bit counter, saturation is reached in a few hundred cycles: the stall counters reach it through single-cycle increments, and the latency counter reaches it after about seventeen cycles at the maximum outstanding count of 15. That latency case also exercises a clamped addition that overshoots the limit by more than one step. The vector table mixes enable, start and stall patterns across both groups, so start priority, holding while disabled, and group independence are all checked against a reference model in the bench.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  typedef enum logic [1:0] {
    KIND_RD_STALL = 2'd0,
    KIND_WR_STALL = 2'd1,
    KIND_RD_LAT   = 2'd2,
    KIND_NONE     = 2'd3
  } cnt_kind_e;

  localparam int NUM_KIND = 3;
endpackage

// File: rtl/perf_sat_counter.sv
module perf_sat_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
    if (clr_i)      cnt_d = '0;
    else if (!en_i) cnt_d = cnt_q;
    else if (sum[CNT_W]) cnt_d = CNT_MAX;  // clamp instead of wrap
    else            cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);  // R1
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_o));  // R4
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);  // R5
  AST_NEVER_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o >= $past(cnt_o));  // R2
endmodule

// File: rtl/perf_grp_counters.sv
module perf_grp_counters
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int OSTD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              rd_stall_i,
  input  logic              wr_stall_i,
  input  logic [OSTD_W-1:0] rd_ostd_i,
  output logic [CNT_W-1:0]  cnt_o [NUM_KIND]
);
  logic [OSTD_W-1:0] inc [NUM_KIND];

  always_comb begin
    inc[KIND_RD_STALL] = OSTD_W'(rd_stall_i);
    inc[KIND_WR_STALL] = OSTD_W'(wr_stall_i);
    inc[KIND_RD_LAT]   = rd_ostd_i;
  end

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    perf_sat_counter #(
      .CNT_W (CNT_W),
      .INC_W (OSTD_W)
    ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .clr_i  (start_i),
      .inc_i  (inc[k]),
      .cnt_o  (cnt_o[k])
    );
  end

  AST_STALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !rd_stall_i) |=> $stable(cnt_o[KIND_RD_STALL]));  // R2
endmodule

// File: rtl/perf_layer_counters.sv
module perf_layer_counters
  import perf_cnt_pkg::*;
#(
  parameter int NUM_GRP = 2,
  parameter int CNT_W   = 32,
  parameter int OSTD_W  = 8,
  parameter int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cnt_en_i,
  input  logic [NUM_GRP-1:0]        grp_start_i,
  input  logic [NUM_GRP-1:0]        rd_stall_i,
  input  logic [NUM_GRP-1:0]        wr_stall_i,
  input  logic [NUM_GRP*OSTD_W-1:0] rd_ostd_i,
  input  logic [GRP_W-1:0]          rd_grp_i,
  input  logic [1:0]                rd_kind_i,
  output logic [CNT_W-1:0]          rd_data_o
);
  logic [CNT_W-1:0] cnt [NUM_GRP][NUM_KIND];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    perf_grp_counters #(
      .CNT_W  (CNT_W),
      .OSTD_W (OSTD_W)
    ) u_grp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (cnt_en_i),
      .start_i    (grp_start_i[g]),
      .rd_stall_i (rd_stall_i[g]),
      .wr_stall_i (wr_stall_i[g]),
      .rd_ostd_i  (rd_ostd_i[g*OSTD_W +: OSTD_W]),
      .cnt_o      (cnt[g])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int k = 0; k < NUM_KIND; k++) begin
        if (int'(rd_grp_i) == g && int'(rd_kind_i) == k) rd_data_o = cnt[g][k];
      end
    end
  end

  AST_START_CLEARS_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_start_i[0] |=> cnt[0][KIND_RD_LAT] == '0);  // R1
endmodule

// File: tb/perf_layer_counters_tb_top.sv
`timescale 1ns/1ps
module perf_layer_counters_tb_top;
  localparam int NUM_GRP = 2;
  localparam int CNT_W   = 8;
  localparam int OSTD_W  = 4;
  localparam int GRP_W   = 1;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cnt_en_i = 1'b0;
  logic [NUM_GRP-1:0] grp_start_i = '0, rd_stall_i = '0, wr_stall_i = '0;
  logic [NUM_GRP*OSTD_W-1:0] rd_ostd_i = '0;
  logic [GRP_W-1:0] rd_grp_i = '0;
  logic [1:0] rd_kind_i = '0;
  logic [CNT_W-1:0] rd_data_o;

  int checks = 0, errors = 0;
  logic [CNT_W-1:0] m [NUM_GRP][3];

  always #5 clk_i = ~clk_i;

  perf_layer_counters #(.NUM_GRP(NUM_GRP), .CNT_W(CNT_W), .OSTD_W(OSTD_W), .GRP_W(GRP_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .grp_start_i(grp_start_i),
    .rd_stall_i(rd_stall_i), .wr_stall_i(wr_stall_i), .rd_ostd_i(rd_ostd_i),
    .rd_grp_i(rd_grp_i), .rd_kind_i(rd_kind_i), .rd_data_o(rd_data_o));

  // {en, start[1:0], rd_stall[1:0], wr_stall[1:0], ostd1, ostd0}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 2'b00, 2'b01, 2'b10, 4'd0, 4'd3},
    {1'b1, 2'b00, 2'b11, 2'b11, 4'd5, 4'd1},
    {1'b1, 2'b00, 2'b10, 2'b00, 4'd2, 4'd0},
    {1'b0, 2'b00, 2'b11, 2'b11, 4'd9, 4'd9},
    {1'b0, 2'b00, 2'b11, 2'b01, 4'd7, 4'd7},
    {1'b1, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0},
    {1'b1, 2'b01, 2'b11, 2'b11, 4'd4, 4'd4},
    {1'b1, 2'b00, 2'b01, 2'b01, 4'd6, 4'd2},
    {1'b1, 2'b10, 2'b11, 2'b11, 4'd8, 4'd8},
    {1'b1, 2'b00, 2'b11, 2'b10, 4'd1, 4'd15},
    {1'b0, 2'b01, 2'b11, 2'b11, 4'd3, 4'd3},
    {1'b1, 2'b00, 2'b01, 2'b00, 4'd0, 4'd1},
    {1'b1, 2'b11, 2'b11, 2'b11, 4'd15, 4'd15},
    {1'b1, 2'b00, 2'b10, 2'b01, 4'd12, 4'd0},
    {1'b1, 2'b00, 2'b11, 2'b11, 4'd15, 4'd14},
    {1'b0, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0}
  };

  function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] a, int b);
    int s = int'(a) + b;
    return (s > int'(MAXV)) ? MAXV : CNT_W'(s);
  endfunction

  task automatic chk(string req, logic [CNT_W-1:0] got, logic [CNT_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic read_ctr(int g, int k, output logic [CNT_W-1:0] v);
    rd_grp_i = GRP_W'(g);
    rd_kind_i = 2'(k);
    #0.2;
    v = rd_data_o;
  endtask

  task automatic check_all(string req);
    logic [CNT_W-1:0] v;
    for (int g = 0; g < NUM_GRP; g++)
      for (int k = 0; k < 3; k++) begin
        read_ctr(g, k, v);
        chk(req, v, m[g][k]);
      end
  endtask

  // drive just after negedge, model the coming posedge, wait to next negedge
  task automatic apply(logic [14:0] v);
    cnt_en_i = v[14];
    grp_start_i = v[13:12];
    rd_stall_i = v[11:10];
    wr_stall_i = v[9:8];
    rd_ostd_i = v[7:0];
    for (int g = 0; g < NUM_GRP; g++) begin
      if (v[12+g]) begin
        for (int k = 0; k < 3; k++) m[g][k] = '0;
      end else if (v[14]) begin
        m[g][0] = sat_add(m[g][0], int'(v[10+g]));
        m[g][1] = sat_add(m[g][1], int'(v[8+g]));
        m[g][2] = sat_add(m[g][2], int'(v[g*4 +: 4]));
      end
    end
    @(negedge clk_i);
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] v;
    for (int g = 0; g < NUM_GRP; g++)
      for (int k = 0; k < 3; k++) m[g][k] = '0;
    #12;
    @(negedge clk_i);
    check_all("R7 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector table: R1 R2 R3 R4 R8
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check_all("R1 R2 R3 R4 R8 table");
    end

    // R6: kind 3 reads zero, repeated reads do not clear
    read_ctr(0, 3, v);
    chk("R6 kind none", v, '0);
    read_ctr(1, 0, v);
    check_all("R6 read no clear");

    // R5: saturate all counters
    for (int n = 0; n < 300; n++) apply({1'b1, 2'b00, 2'b11, 2'b11, 4'd15, 4'd15});
    check_all("R5 saturate");
    read_ctr(0, 2, v);
    chk("R5 latency clamp", v, MAXV);
    apply({1'b1, 2'b00, 2'b11, 2'b11, 4'd15, 4'd15});
    read_ctr(1, 0, v);
    chk("R5 hold at max", v, MAXV);

    // R8: start group 0 only
    apply({1'b1, 2'b01, 2'b00, 2'b00, 4'd0, 4'd0});
    check_all("R8 independent start");
    read_ctr(1, 1, v);
    chk("R8 other group kept", v, MAXV);

    // R4: disabled start still clears; stalls ignored
    apply({1'b0, 2'b10, 2'b11, 2'b11, 4'd5, 4'd5});
    check_all("R4 disabled start clears");
    apply({1'b0, 2'b00, 2'b11, 2'b11, 4'd5, 4'd5});
    read_ctr(0, 0, v);
    chk("R4 disabled hold", v, '0);

    // R2 R3 exact single steps
    apply({1'b1, 2'b00, 2'b01, 2'b00, 4'd0, 4'd6});
    read_ctr(0, 0, v);
    chk("R2 single step", v, 8'd1);
    read_ctr(0, 2, v);
    chk("R3 add ostd", v, 8'd6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule